// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Alternate-Function Routing

This block is one eight-pin general-purpose I/O port for a microcontroller-style subsystem. Software talks to it through a plain register bus with a write strobe, a two-bit address, write data and a combinational read-data return. The bus reaches three registers. The direction register has one bit per pin, and a 1 there turns the pin into an input. The output latch holds the value that output pins drive. The pin-read location returns the level seen on each pad after a synchronizer.

On the pad side, each pin has an output value, an output enable and an input level. Three configuration controls hand particular pins to peripherals. The PWM-select control puts a complementary PWM pair on the top two pins. The serial remap control places serial data out on pin 1, serial data in on pin 2 and serial clock on pin 3. The fault remap control routes pin 4 to the PWM fault input. A remapped output pin takes its data from the peripheral but still follows its direction bit. A pin remapped as a peripheral input never drives, whatever its direction bit says. The configuration controls are static strap-like levels, so no handshake is involved. The register bus is also a plain control interface without back-pressure: every access completes in the cycle it is presented.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset every direction bit reads 1, the output latch reads 0x00 and all eight output enables are 0.
- R2: A write (bus_wr=1) takes effect at the next rising clock edge. Address 0 selects the direction register and address 1 selects the output latch. The read data path returns the addressed register combinationally.
- R3: A read at address 1 returns the stored latch value and not the pad level, so a read-modify-write of the latch acts on latched data.
- R4: A read at address 2 returns the pad input levels through a two-flop synchronizer. A pad level applied before a clock edge shows up after the second rising edge and not after the first.
- R5: Each pin on its own takes pad_oe[i] = ~direction[i]. When a pin is not remapped, pad_out[i] equals latch[i].
- R6: With pwm_sel=1, pad_out[6] carries pwm_a and pad_out[7] carries pwm_b. Their output enables still follow direction bits 6 and 7. With pwm_sel=0 those pins drive the latch.
- R7: With ser_remap=1, pad_out[1] carries ser_sdo and pad_out[3] carries ser_sck_o, with enables from their direction bits. ser_sck_i returns the synchronized level of pin 3, and it is 0 when not remapped.
- R8: With ser_remap=1, pad_oe[2] is 0 whatever direction bit 2 holds, and ser_sdi returns the synchronized level of pin 2. When not remapped, ser_sdi is 0.
- R9: With flt_remap=1, pad_oe[4] is 0 whatever direction bit 4 holds, and flt_in returns the synchronized level of pin 4. When not remapped, flt_in is 0.
- R10: A write to address 2 (pin-read location) loads the output latch.
- R11: A write to address 3 changes neither register, and a read at address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 direction, 1 latch, 2 pin read, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| pwm_sel | input | 1 | Route the PWM pair onto pins 7:6 |
| ser_remap | input | 1 | Route the serial interface onto pins 3:1 |
| flt_remap | input | 1 | Route pin 4 to the fault input |
| pwm_a | input | 1 | PWM data for pin 6 |
| pwm_b | input | 1 | Complementary PWM data for pin 7 |
| ser_sdo | input | 1 | Serial data out, for pin 1 |
| ser_sck_o | input | 1 | Serial clock out, for pin 3 |
| ser_sdi | output | 1 | Serial data in, from pin 2 |
| ser_sck_i | output | 1 | Serial clock in, from pin 3 |
| flt_in | output | 1 | Fault input, from pin 4 |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
A table of patterns drives direction, latch, pad levels and the three remap controls together. It includes alternating and complementary direction and latch bytes. The latch and pad levels are chosen to differ, so a pin taking the wrong source (latch, PWM, serial or pad) shows up as a flipped bit at the right position. Each remap control is tried alone and together with the others, and with direction bits cleared, so a forced-off enable can be told apart from one that simply follows the direction register. Directed cases cover the reset values, the exact two-edge synchronizer latency, and latch readback against a different pad level. They also cover writes through the pin-read address and writes to the unused address.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  typedef enum logic [1:0] {
    REG_DIR  = 2'd0,
    REG_LAT  = 2'd1,
    REG_PIN  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int PIN_SDO  = 1;
  localparam int PIN_SDI  = 2;
  localparam int PIN_SCK  = 3;
  localparam int PIN_FLT  = 4;
  localparam int PIN_PWMA = 6;
  localparam int PIN_PWMB = 7;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_mux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
    end else if (wr) begin
      case (sel)
        REG_DIR: dir_q <= wdata;
        REG_LAT,
        REG_PIN: lat_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_DIR: rdata = dir_q;
      REG_LAT: rdata = lat_q;
      REG_PIN: rdata = pin_sync;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_mux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] lat_q,
  input  logic         pwm_sel,
  input  logic         ser_remap,
  input  logic         flt_remap,
  input  logic         pwm_a,
  input  logic         pwm_b,
  input  logic         ser_sdo,
  input  logic         ser_sck_o,
  input  logic         sync_sdi,
  input  logic         sync_sck,
  input  logic         sync_flt,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic         ser_sdi,
  output logic         ser_sck_i,
  output logic         flt_in
);
  logic [W-1:0] in_only;

  always_comb begin
    in_only          = '0;
    in_only[PIN_SDI] = ser_remap;
    in_only[PIN_FLT] = flt_remap;
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      if (i == PIN_PWMA) begin : g_pwma
        assign pad_out[i] = pwm_sel ? pwm_a : lat_q[i];
      end else if (i == PIN_PWMB) begin : g_pwmb
        assign pad_out[i] = pwm_sel ? pwm_b : lat_q[i];
      end else if (i == PIN_SDO) begin : g_sdo
        assign pad_out[i] = ser_remap ? ser_sdo : lat_q[i];
      end else if (i == PIN_SCK) begin : g_sck
        assign pad_out[i] = ser_remap ? ser_sck_o : lat_q[i];
      end else begin : g_plain
        assign pad_out[i] = lat_q[i];
      end
      assign pad_oe[i] = ~dir_q[i] & ~in_only[i];
    end
  endgenerate

  assign ser_sdi   = ser_remap & sync_sdi;
  assign ser_sck_i = ser_remap & sync_sck;
  assign flt_in    = flt_remap & sync_flt;
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_mux_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic              pwm_sel,
  input  logic              ser_remap,
  input  logic              flt_remap,
  input  logic              pwm_a,
  input  logic              pwm_b,
  input  logic              ser_sdo,
  input  logic              ser_sck_o,
  output logic              ser_sdi,
  output logic              ser_sck_i,
  output logic              flt_in,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe
);
  logic [PORT_W-1:0] pin_sync;
  logic [PORT_W-1:0] dir_q;
  logic [PORT_W-1:0] lat_q;

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  gpio_regs #(.W(PORT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata),
    .dir_q    (dir_q),
    .lat_q    (lat_q)
  );

  gpio_pinmux #(.W(PORT_W)) u_mux (
    .dir_q     (dir_q),
    .lat_q     (lat_q),
    .pwm_sel   (pwm_sel),
    .ser_remap (ser_remap),
    .flt_remap (flt_remap),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .ser_sdo   (ser_sdo),
    .ser_sck_o (ser_sck_o),
    .sync_sdi  (pin_sync[PIN_SDI]),
    .sync_sck  (pin_sync[PIN_SCK]),
    .sync_flt  (pin_sync[PIN_FLT]),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .ser_sdi   (ser_sdi),
    .ser_sck_i (ser_sck_i),
    .flt_in    (flt_in)
  );
endmodule

// File: rtl/gpio_mux_port_chk.sv
module gpio_mux_port_chk #(
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [PORT_W-1:0] bus_wdata,
  input logic [PORT_W-1:0] bus_rdata,
  input logic              pwm_sel,
  input logic              ser_remap,
  input logic              flt_remap,
  input logic              pwm_a,
  input logic              pwm_b,
  input logic              ser_sdo,
  input logic              ser_sck_o,
  input logic              ser_sdi,
  input logic              ser_sck_i,
  input logic              flt_in,
  input logic [PORT_W-1:0] pad_in,
  input logic [PORT_W-1:0] pad_out,
  input logic [PORT_W-1:0] pad_oe
);
  AST_SDI_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ser_remap |-> !pad_oe[2]); // R8

  AST_FLT_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    flt_remap |-> !pad_oe[4]); // R9

  AST_LAT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> pad_out[0] == $past(bus_wdata[0])); // R2

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0 && !flt_remap) |-> pad_oe[4] == ~bus_rdata[4]); // R5

  AST_LAT_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> bus_rdata[5] == pad_out[5]); // R3

  AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> bus_rdata == '0); // R11
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) chk_i (.*);

// File: tb/gpio_mux_port_tb_top.sv
`timescale 1ns/1ps
module gpio_mux_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pwm_sel = 1'b0, ser_remap = 1'b0, flt_remap = 1'b0;
  logic       pwm_a = 1'b0, pwm_b = 1'b0, ser_sdo = 1'b0, ser_sck_o = 1'b0;
  logic       ser_sdi, ser_sck_i, flt_in;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mux_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_sel(pwm_sel),
    .ser_remap(ser_remap), .flt_remap(flt_remap), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .ser_sdo(ser_sdo), .ser_sck_o(ser_sck_o), .ser_sdi(ser_sdi),
    .ser_sck_i(ser_sck_i), .flt_in(flt_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // vector: dir[30:23] lat[22:15] pad[14:7] pwm_sel[6] ser[5] flt[4] pwm_a[3] pwm_b[2] sdo[1] sck[0]
  localparam int NV = 8;
  localparam logic [30:0] VEC [NV] = '{
    {8'h00, 8'hA5, 8'h5A, 3'b000, 4'b0000},
    {8'hFF, 8'h3C, 8'hC3, 3'b000, 4'b1111},
    {8'h00, 8'h00, 8'hFF, 3'b100, 4'b1001},
    {8'h00, 8'hFF, 8'h00, 3'b100, 4'b0110},
    {8'h00, 8'h00, 8'h1C, 3'b010, 4'b0011},
    {8'hF0, 8'hFF, 8'h04, 3'b010, 4'b0001},
    {8'h00, 8'h55, 8'h10, 3'b001, 4'b0000},
    {8'h0F, 8'hAA, 8'hEB, 3'b111, 4'b1010}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_read(2'd0, rd); check("R1 dir", rd, 8'hFF);
    bus_read(2'd1, rd); check("R1 lat", rd, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] dir, lat, pin, eo, ee;
      logic ps, sr, fr;
      {dir, lat, pin, ps, sr, fr, pwm_a, pwm_b, ser_sdo, ser_sck_o} = VEC[v];
      pwm_sel = ps; ser_remap = sr; flt_remap = fr; pad_in = pin;
      bus_write(2'd0, dir);
      bus_write(2'd1, lat);
      repeat (2) @(negedge clk);
      eo = lat; ee = ~dir;
      if (ps) begin eo[6] = pwm_a; eo[7] = pwm_b; end
      if (sr) begin eo[1] = ser_sdo; eo[3] = ser_sck_o; ee[2] = 1'b0; end
      if (fr) ee[4] = 1'b0;
      check("R5 R6 R7 pad_out", pad_out, eo);
      check("R5 R8 R9 pad_oe", pad_oe, ee);
      bus_read(2'd0, rd); check("R2 dir read", rd, dir);
      bus_read(2'd1, rd); check("R3 lat read", rd, lat);
      bus_read(2'd2, rd); check("R4 pin read", rd, pin);
      check("R7 sck_i", {7'd0, ser_sck_i}, {7'd0, sr & pin[3]});
      check("R8 sdi", {7'd0, ser_sdi}, {7'd0, sr & pin[2]});
      check("R9 flt", {7'd0, flt_in}, {7'd0, fr & pin[4]});
    end

    // R4 exact synchronizer latency
    pwm_sel = 0; ser_remap = 0; flt_remap = 0;
    pad_in = 8'h00; repeat (3) @(negedge clk);
    pad_in = 8'h96;
    @(negedge clk); bus_read(2'd2, rd); check("R4 after one edge", rd, 8'h00);
    @(negedge clk); bus_read(2'd2, rd); check("R4 after two edges", rd, 8'h96);

    // R3 latch read differs from pad level
    bus_write(2'd0, 8'hFF);
    bus_write(2'd1, 8'h0F);
    bus_read(2'd1, rd); check("R3 lat not pad", rd, 8'h0F);

    // R10 write via pin-read address loads latch
    bus_write(2'd2, 8'hC6);
    bus_read(2'd1, rd); check("R10 lat", rd, 8'hC6);
    check("R10 pad_out", pad_out, 8'hC6);

    // R11 unused address
    bus_write(2'd3, 8'h33);
    bus_read(2'd0, rd); check("R11 dir kept", rd, 8'hFF);
    bus_read(2'd1, rd); check("R11 lat kept", rd, 8'hC6);
    bus_read(2'd3, rd); check("R11 read zero", rd, 8'h00);

    // R8 R9 forced off with direction cleared and remap off/on
    bus_write(2'd0, 8'h00);
    check("R5 all drive", pad_oe, 8'hFF);
    ser_remap = 1; flt_remap = 1; #0.5;
    check("R8 R9 forced off", pad_oe, 8'hEB);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule